// File: doc/BRIEF.md
# Configuration Cycle Type Converter

This block decides how a bridge forwards a configuration request, one request per cycle. A request carries a 32-bit address, a bus command and the side it arrived on. The block also takes three bus numbers that the bridge holds elsewhere: its own upstream bus, the bus directly below it, and the highest bus number behind it. For each request it produces one of four actions. The request can be dropped. It can be rewritten as a Type 0 access on the downstream bus with a one-hot device select placed on the upper address lines. It can be passed on unchanged as a Type 1 access. Or it can be turned into a special cycle.

The result is registered and appears one clock after the request. The block's output also carries the single-transfer rule for configuration traffic. Every forwarded request is marked so that the bus engine ends the transfer after one dword. Such a transfer is neither posted nor prefetched. Bus handshakes and the storage of the bus-number registers are outside this block.

Top module: `cfgconv_top`

## Requirements
- R1: After reset `out_valid` is 0, `out_action` is 0 and `out_addr` is 0. Every request presented with `req_valid` high produces its result exactly one clock later, and `out_valid` is low in any cycle that follows a cycle without a request.
- R2: A configuration read (command 4'hA) or write (command 4'hB) from the primary side counts as Type 1 when address bits 1:0 are 01. The Type 1 fields are bus number in bits 23:16, device in bits 15:11, function in bits 10:8 and register in bits 7:2. When the bus number equals `sec_bus`, the request becomes action 1 (Type 0). The output address carries function and register in the same bits, zeros in bits 15:11 and 1:0, and the command unchanged.
- R3: In a Type 0 result for a device number from 0 to 15, exactly one of address bits 31:16 is set: bit 16 plus the device number.
- R4: In a Type 0 result for a device number from 16 to 31, the request is still forwarded as action 1, but address bits 31:16 are all zero.
- R5: A primary-side Type 1 request whose bus number is above `sec_bus` and at or below `sub_bus` becomes action 2. The address and command are passed on unchanged.
- R6: A primary-side Type 1 request whose bus number is below `sec_bus` or above `sub_bus` gives action 0. A dropped result always shows `out_addr` = 0 and `out_cmd` = 0.
- R7: A secondary-side configuration write in Type 1 form is converted to a special cycle (action 3, command 4'h1, address unchanged) when three conditions hold: its bus number equals `pri_bus`, its device number is 31, and its function is 7 with register 0.
- R8: A primary-side configuration write that meets the R2 bus condition and uses the device 31, function 7, register 0 encoding becomes a special cycle (action 3, command 4'h1, address unchanged). A read with that encoding stays an ordinary Type 0 conversion.
- R9: A special-cycle command (4'h1) arriving on either side is dropped. Any command other than a configuration read or write is dropped. A configuration request whose address bits 1:0 are not 01 is dropped.
- R10: `out_single` is 1 exactly when a valid result has a non-zero action. This is the one-dword disconnect with no posting or prefetch.
- R11: A secondary-side configuration request that does not meet R7 is dropped. This covers a read with the special encoding, a write to another bus, and an ordinary write to a bus behind the bridge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_from_sec | input | 1 | 1 when the request came from the secondary side |
| req_cmd | input | 4 | Bus command of the request |
| req_addr | input | 32 | Address phase of the request |
| pri_bus | input | 8 | Bus number on the upstream side |
| sec_bus | input | 8 | Bus number directly below the bridge |
| sub_bus | input | 8 | Highest bus number behind the bridge |
| out_valid | output | 1 | A result is present this cycle |
| out_action | output | 2 | 0 drop, 1 Type 0, 2 Type 1, 3 special cycle |
| out_addr | output | 32 | Translated address |
| out_cmd | output | 4 | Translated command |
| out_single | output | 1 | Disconnect after one dword |

## Verification
The case hardest to reach is a request that carries the special-cycle encoding but misses one of the other conditions: a read instead of a write, the wrong side, or a bus number next to the right one. A near miss of this kind must fall back to an ordinary Type 0 conversion or be dropped, depending on which condition failed. The stimulus table therefore holds the device 31, function 7, register 0 address in each of these combinations next to the matching write. It also places bus numbers on both sides of each range edge, including a narrowed window where `sub_bus` equals `sec_bus`.

// File: rtl/cfgconv_pkg.sv
package cfgconv_pkg;
    localparam int ADDR_W   = 32;
    localparam int CMD_W    = 4;
    localparam int DEV_W    = 5;
    localparam int FN_W     = 3;
    localparam int REG_W    = 6;
    localparam int REG_LSB  = 2;
    localparam int FN_LSB   = REG_LSB + REG_W;
    localparam int DEV_LSB  = FN_LSB + FN_W;
    localparam int BUS_LSB  = DEV_LSB + DEV_W;
    localparam int DEC_W    = 24;

    localparam logic [CMD_W-1:0] CMD_SPECIAL = 4'h1;
    localparam logic [CMD_W-1:0] CMD_CFG_RD  = 4'hA;
    localparam logic [CMD_W-1:0] CMD_CFG_WR  = 4'hB;

    typedef enum logic [1:0] {
        ACT_DROP    = 2'd0,
        ACT_TYPE0   = 2'd1,
        ACT_TYPE1   = 2'd2,
        ACT_SPECIAL = 2'd3
    } act_e;

    typedef struct packed {
        logic              valid;
        act_e              act;
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic              single;
    } result_t;
endpackage

// File: rtl/cfgconv_field_decode.sv
module cfgconv_field_decode
    import cfgconv_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic [DEC_W-1:0] addr_lo,
    output logic             is_type1,
    output logic [BUS_W-1:0] bus_num,
    output logic [DEV_W-1:0] dev_num,
    output logic             spc_enc
);
    localparam logic [DEV_W-1:0] SPC_DEV = '1;
    localparam logic [FN_W-1:0]  SPC_FN  = '1;

    logic [FN_W-1:0]  fn_num;
    logic [REG_W-1:0] reg_num;

    always_comb begin
        is_type1 = (addr_lo[1:0] == 2'b01);
        bus_num  = addr_lo[BUS_LSB +: BUS_W];
        dev_num  = addr_lo[DEV_LSB +: DEV_W];
        fn_num   = addr_lo[FN_LSB +: FN_W];
        reg_num  = addr_lo[REG_LSB +: REG_W];
        spc_enc  = (dev_num == SPC_DEV) && (fn_num == SPC_FN) && (reg_num == '0);
    end
endmodule

// File: rtl/cfgconv_idsel_gen.sv
module cfgconv_idsel_gen
    import cfgconv_pkg::*;
#(
    parameter int SEL_N = 16
) (
    input  logic [DEV_W-1:0] dev_num,
    output logic [SEL_N-1:0] sel
);
    for (genvar i = 0; i < SEL_N; i++) begin : g_line
        assign sel[i] = (dev_num == DEV_W'(i));
    end
endmodule

// File: rtl/cfgconv_route_sel.sv
module cfgconv_route_sel
    import cfgconv_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             from_sec,
    input  logic [CMD_W-1:0] cmd,
    input  logic             is_type1,
    input  logic [BUS_W-1:0] bus_num,
    input  logic             spc_enc,
    input  logic [BUS_W-1:0] pri_bus,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output act_e             act
);
    logic is_cfg;
    logic is_wr;
    logic in_range;

    always_comb begin
        is_cfg   = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
        is_wr    = (cmd == CMD_CFG_WR);
        in_range = (bus_num > sec_bus) && (bus_num <= sub_bus);
        act      = ACT_DROP;
        if (is_cfg && is_type1) begin
            if (!from_sec) begin
                if (bus_num == sec_bus) begin
                    act = (is_wr && spc_enc) ? ACT_SPECIAL : ACT_TYPE0;
                end else if (in_range) begin
                    act = ACT_TYPE1;
                end
            end else if (is_wr && spc_enc && (bus_num == pri_bus)) begin
                act = ACT_SPECIAL;
            end
        end
    end
endmodule

// File: rtl/cfgconv_top.sv
module cfgconv_top
    import cfgconv_pkg::*;
#(
    parameter int BUS_W     = 8,
    parameter int IDSEL_LSB = 16,
    parameter int IDSEL_N   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_from_sec,
    input  logic [3:0]        req_cmd,
    input  logic [31:0]       req_addr,
    input  logic [BUS_W-1:0]  pri_bus,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              out_valid,
    output logic [1:0]        out_action,
    output logic [31:0]       out_addr,
    output logic [3:0]        out_cmd,
    output logic              out_single
);
    localparam int KEEP_W = FN_LSB + FN_W - REG_LSB;

    logic             is_type1;
    logic [BUS_W-1:0] bus_num;
    logic [DEV_W-1:0] dev_num;
    logic             spc_enc;
    logic [IDSEL_N-1:0] idsel;
    act_e             act;
    result_t          res_d;
    result_t          res_q;

    cfgconv_field_decode #(.BUS_W(BUS_W)) u_dec (
        .addr_lo  (req_addr[DEC_W-1:0]),
        .is_type1 (is_type1),
        .bus_num  (bus_num),
        .dev_num  (dev_num),
        .spc_enc  (spc_enc)
    );

    cfgconv_idsel_gen #(.SEL_N(IDSEL_N)) u_sel (
        .dev_num (dev_num),
        .sel     (idsel)
    );

    cfgconv_route_sel #(.BUS_W(BUS_W)) u_route (
        .from_sec (req_from_sec),
        .cmd      (req_cmd),
        .is_type1 (is_type1),
        .bus_num  (bus_num),
        .spc_enc  (spc_enc),
        .pri_bus  (pri_bus),
        .sec_bus  (sec_bus),
        .sub_bus  (sub_bus),
        .act      (act)
    );

    always_comb begin
        res_d        = '0;
        res_d.valid  = req_valid;
        if (req_valid) begin
            res_d.act    = act;
            res_d.single = (act != ACT_DROP);
            unique case (act)
                ACT_TYPE0: begin
                    res_d.addr[IDSEL_LSB +: IDSEL_N]  = idsel;
                    res_d.addr[REG_LSB +: KEEP_W]     = req_addr[REG_LSB +: KEEP_W];
                    res_d.cmd                         = req_cmd;
                end
                ACT_TYPE1: begin
                    res_d.addr = req_addr;
                    res_d.cmd  = req_cmd;
                end
                ACT_SPECIAL: begin
                    res_d.addr = req_addr;
                    res_d.cmd  = CMD_SPECIAL;
                end
                default: begin
                    res_d.addr = '0;
                    res_d.cmd  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.valid;
    assign out_action = res_q.act;
    assign out_addr   = res_q.addr;
    assign out_cmd    = res_q.cmd;
    assign out_single = res_q.single;
endmodule

// File: rtl/cfgconv_chk.sv
module cfgconv_chk
    import cfgconv_pkg::*;
#(
    parameter int IDSEL_LSB = 16,
    parameter int IDSEL_N   = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [3:0]  req_cmd,
    input logic [31:0] req_addr,
    input logic        out_valid,
    input logic [1:0]  out_action,
    input logic [31:0] out_addr,
    input logic [3:0]  out_cmd,
    input logic        out_single
);
    localparam int DEV_MSB = DEV_LSB + DEV_W - 1;

    a_r1_result_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r1_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid));

    a_r2_type0_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == ACT_TYPE0) |-> (out_addr[1:0] == 2'b00));

    a_r3_idsel_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == ACT_TYPE0) |-> $onehot0(out_addr[IDSEL_LSB +: IDSEL_N]));

    a_r4_high_device_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == ACT_TYPE0 && $past(req_addr[DEV_MSB]))
        |-> (out_addr[IDSEL_LSB +: IDSEL_N] == '0));

    a_r5_type1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == ACT_TYPE1)
        |-> (out_addr == $past(req_addr) && out_cmd == $past(req_cmd)));

    a_r6_drop_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == ACT_DROP) |-> (out_addr == '0 && out_cmd == '0));

    a_r7_special_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == ACT_SPECIAL)
        |-> (out_cmd == CMD_SPECIAL && out_addr == $past(req_addr)));

    a_r10_single_on_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action != ACT_DROP) |-> out_single);

    a_r10_no_single_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_single);
endmodule

bind cfgconv_top cfgconv_chk #(.IDSEL_LSB(IDSEL_LSB), .IDSEL_N(IDSEL_N)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_cmd    (req_cmd),
    .req_addr   (req_addr),
    .out_valid  (out_valid),
    .out_action (out_action),
    .out_addr   (out_addr),
    .out_cmd    (out_cmd),
    .out_single (out_single)
);

// File: tb/cfgconv_top_tb_top.sv
module cfgconv_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_from_sec = 1'b0;
    logic [3:0]  req_cmd = 4'h0;
    logic [31:0] req_addr = 32'h0;
    logic [7:0]  pri_bus = 8'h02;
    logic [7:0]  sec_bus = 8'h05;
    logic [7:0]  sub_bus = 8'h09;
    logic        out_valid;
    logic [1:0]  out_action;
    logic [31:0] out_addr;
    logic [3:0]  out_cmd;
    logic        out_single;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cfgconv_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_from_sec(req_from_sec),
        .req_cmd(req_cmd), .req_addr(req_addr), .pri_bus(pri_bus), .sec_bus(sec_bus),
        .sub_bus(sub_bus), .out_valid(out_valid), .out_action(out_action),
        .out_addr(out_addr), .out_cmd(out_cmd), .out_single(out_single)
    );

    function automatic logic [31:0] mk(input logic [7:0] bus, input logic [4:0] dev,
                                       input logic [2:0] fn, input logic [5:0] rg);
        return {8'h00, bus, dev, fn, rg, 2'b01};
    endfunction

    function automatic logic [31:0] t0(input logic [4:0] dev, input logic [2:0] fn,
                                       input logic [5:0] rg);
        logic [31:0] a;
        a = 32'h0;
        if (dev < 5'd16) a[16 + int'(dev)] = 1'b1;
        a[10:8] = fn;
        a[7:2]  = rg;
        return a;
    endfunction

    function automatic string rq(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";   10: return "R10"; default: return "R11";
        endcase
    endfunction

    typedef struct packed {
        logic        sec_side;
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [1:0]  act;
        logic [31:0] eaddr;
        logic [3:0]  ecmd;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'hA, mk(8'h05, 5'd0,  3'd0, 6'h00), 2'd1, t0(5'd0, 3'd0, 6'h00),  4'hA, 4'd3},  // R3
        '{1'b0, 4'hB, mk(8'h05, 5'd15, 3'd3, 6'h12), 2'd1, t0(5'd15, 3'd3, 6'h12), 4'hB, 4'd2},  // R2
        '{1'b0, 4'hA, mk(8'h05, 5'd16, 3'd1, 6'h04), 2'd1, t0(5'd16, 3'd1, 6'h04), 4'hA, 4'd4},  // R4
        '{1'b0, 4'hA, mk(8'h07, 5'd3,  3'd2, 6'h01), 2'd2, mk(8'h07, 5'd3, 3'd2, 6'h01), 4'hA, 4'd5}, // R5
        '{1'b0, 4'hB, mk(8'h09, 5'd9,  3'd0, 6'h3F), 2'd2, mk(8'h09, 5'd9, 3'd0, 6'h3F), 4'hB, 4'd5}, // R5
        '{1'b0, 4'hA, mk(8'h0A, 5'd1,  3'd0, 6'h00), 2'd0, 32'h0, 4'h0, 4'd6},  // R6
        '{1'b0, 4'hA, mk(8'h04, 5'd1,  3'd0, 6'h00), 2'd0, 32'h0, 4'h0, 4'd6},  // R6
        '{1'b0, 4'hA, mk(8'h02, 5'd1,  3'd0, 6'h00), 2'd0, 32'h0, 4'h0, 4'd6},  // R6
        '{1'b1, 4'hB, mk(8'h02, 5'd31, 3'd7, 6'h00), 2'd3, mk(8'h02, 5'd31, 3'd7, 6'h00), 4'h1, 4'd7}, // R7
        '{1'b1, 4'hA, mk(8'h02, 5'd31, 3'd7, 6'h00), 2'd0, 32'h0, 4'h0, 4'd11}, // R11
        '{1'b1, 4'hB, mk(8'h03, 5'd31, 3'd7, 6'h00), 2'd0, 32'h0, 4'h0, 4'd11}, // R11
        '{1'b0, 4'hB, mk(8'h05, 5'd31, 3'd7, 6'h00), 2'd3, mk(8'h05, 5'd31, 3'd7, 6'h00), 4'h1, 4'd8}, // R8
        '{1'b0, 4'hA, mk(8'h05, 5'd31, 3'd7, 6'h00), 2'd1, t0(5'd31, 3'd7, 6'h00), 4'hA, 4'd8},  // R8
        '{1'b0, 4'h1, mk(8'h05, 5'd2,  3'd0, 6'h00), 2'd0, 32'h0, 4'h0, 4'd9},  // R9
        '{1'b1, 4'h1, mk(8'h02, 5'd31, 3'd7, 6'h00), 2'd0, 32'h0, 4'h0, 4'd9},  // R9
        '{1'b0, 4'hA, {8'h00, 8'h05, 5'd2, 3'd0, 6'h01, 2'b00}, 2'd0, 32'h0, 4'h0, 4'd9}, // R9
        '{1'b0, 4'h6, mk(8'h05, 5'd2,  3'd0, 6'h00), 2'd0, 32'h0, 4'h0, 4'd9},  // R9
        '{1'b0, 4'hA, mk(8'h06, 5'd20, 3'd5, 6'h0C), 2'd2, mk(8'h06, 5'd20, 3'd5, 6'h0C), 4'hA, 4'd5}, // R5
        '{1'b1, 4'hB, mk(8'h07, 5'd3,  3'd0, 6'h00), 2'd0, 32'h0, 4'h0, 4'd11}  // R11
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic side, input logic [3:0] cmd, input logic [31:0] addr);
        @(negedge clk);
        req_valid    = 1'b1;
        req_from_sec = side;
        req_cmd      = cmd;
        req_addr     = addr;
        @(negedge clk);
        req_valid    = 1'b0;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                n_run++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "valid at reset", {31'h0, out_valid}, 32'h0);
        chk("R1", "action at reset", {30'h0, out_action}, 32'h0);
        chk("R1", "addr at reset", out_addr, 32'h0);
        chk("R10", "single at reset", {31'h0, out_single}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i].sec_side, VECS[i].cmd, VECS[i].addr);
            chk(rq(int'(VECS[i].tag)), "valid", {31'h0, out_valid}, 32'h1);
            chk(rq(int'(VECS[i].tag)), "action", {30'h0, out_action}, {30'h0, VECS[i].act});
            chk(rq(int'(VECS[i].tag)), "addr", out_addr, VECS[i].eaddr);
            chk(rq(int'(VECS[i].tag)), "cmd", {28'h0, out_cmd}, {28'h0, VECS[i].ecmd});
            chk("R10", "single", {31'h0, out_single}, {31'h0, (VECS[i].act != 2'd0)});
        end

        // R1: no result in the cycle after an idle cycle
        @(negedge clk);
        chk("R1", "valid when idle", {31'h0, out_valid}, 32'h0);

        // R6: empty window when sub_bus equals sec_bus
        sub_bus = 8'h05;
        send(1'b0, 4'hA, mk(8'h06, 5'd1, 3'd0, 6'h00));
        chk("R6", "empty window action", {30'h0, out_action}, 32'h0);
        chk("R6", "empty window addr", out_addr, 32'h0);
        // R2: bus equal to sec still converts in the narrowed window
        send(1'b0, 4'hA, mk(8'h05, 5'd7, 3'd6, 6'h2A));
        chk("R2", "narrow type0 action", {30'h0, out_action}, 32'h1);
        chk("R3", "narrow type0 addr", out_addr, t0(5'd7, 3'd6, 6'h2A));
        sub_bus = 8'h09;

        // R1: reset asserted alongside a request wins
        @(negedge clk);
        rst_n     = 1'b0;
        req_valid = 1'b1;
        req_cmd   = 4'hA;
        req_addr  = mk(8'h05, 5'd1, 3'd0, 6'h00);
        @(negedge clk);
        chk("R1", "valid under reset", {31'h0, out_valid}, 32'h0);
        chk("R1", "addr under reset", out_addr, 32'h0);
        req_valid = 1'b0;
        rst_n     = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule